// File: doc/BRIEF.md
# UART Transmit Path with Holding-Empty Interrupt

This block is the transmit half of a classic byte-oriented UART. Software writes characters into a 16-entry queue. The entry at the front of the queue acts as the holding register. An idle serializer takes that front entry and sends it on the serial line as a frame of one start bit, eight data bits (least significant first) and one stop bit. Each bit lasts sixteen baud-tick enables.

Two status bits come out of the block. One says the holding register and queue are empty. The other says the whole transmit path, serializer included, is empty.

The block also raises a holding-empty interrupt, but this interrupt does not simply follow queue emptiness. If at least two characters were waiting at the same time before the queue emptied, the interrupt comes up at once. Otherwise, including just after reset, it waits nine bit times (144 baud ticks) before asserting, which gives software time to refill the queue. The interrupt clears on any write strobe. It also clears on an identification read made while it is the reported source. A four-bit identification code tells a pending holding-empty interrupt apart from the no-interrupt state.

Top module: `uart_txempty_irq`

## Requirements
- R1: After a synchronous reset: txd is 1, hold_empty is 1, xmit_empty is 1, irq is 0 and iid is 4'b0001.
- R2: The queue holds at most 16 characters waiting behind the serializer. A write strobe that arrives while 16 are waiting is discarded and never transmitted.
- R3: hold_empty is 1 exactly when no character waits in the queue. A write strobe makes it 0 from the next cycle on.
- R4: When the serializer is idle and the queue is not empty at a clock edge, the front character leaves the queue and txd goes to 0 (start bit) at that edge. The frame is then sent as 8 data bits LSB first and a 1 stop bit, each bit held for 16 baud ticks. The serializer is idle again at the 16th tick of the stop bit. An idle line is 1.
- R5: xmit_empty is 1 exactly when hold_empty is 1 and the serializer is idle.
- R6: When the queue occupancy has reached 2 or more since the last time hold_empty rose, the interrupt becomes pending at the clock edge that follows the rise of hold_empty.
- R7: Otherwise the delay rule applies, both after reset and after a rise of hold_empty. The interrupt becomes pending at the 144th baud tick counted while hold_empty stays 1. The tick at the edge that detects the rise is not counted. If hold_empty falls, the count is abandoned.
- R8: A write strobe clears a pending interrupt. It also wins over a set in the same cycle, so irq is 0 in the cycle after any write strobe.
- R9: A read strobe on the identification code clears a pending interrupt only while iid shows 4'b0010. A read made while irq_en is 0 leaves the interrupt pending.
- R10: irq is the pending interrupt gated by irq_en. iid is 4'b0010 while irq is 1 and 4'b0001 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe into the holding register / queue |
| wr_data | input | 8 | Character to queue |
| iid_rd | input | 1 | Read strobe of the identification code |
| irq_en | input | 1 | Enable of the holding-empty interrupt |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register and queue empty |
| xmit_empty | output | 1 | Queue and serializer both empty |
| irq | output | 1 | Holding-empty interrupt request |
| iid | output | 4 | Identification code: 4'b0010 pending, 4'b0001 none |

## Verification
The first pattern queues three characters back to back while the serializer is busy, so that occupancy reaches two. This separates the immediate interrupt from the delayed one. A single late write and the quiet time after reset exercise the 144-tick delay; the bench samples both one tick short of the delay and exactly at it. A burst of twenty all-ones characters with ticks held off fills the queue; since each all-ones frame has a single falling edge, counting falling edges shows exactly which writes were dropped. A long random run then mixes write bursts, identification reads, enable toggles and irregular ticks. Every output is compared each cycle against a bench-side reference model, which catches races between writes, reads and interrupt sets.

// File: rtl/uart_thre_pkg.sv
package uart_thre_pkg;
  localparam logic [3:0] IID_NONE = 4'b0001;
  localparam logic [3:0] IID_THRE = 4'b0010;

  typedef enum logic {
    SER_IDLE = 1'b0,
    SER_BUSY = 1'b1
  } ser_state_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign head    = mem[rd_ptr];

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import uart_thre_pkg::*;
#(
  parameter int W   = 8,
  parameter int TPB = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         baud_tick,
  output logic         busy,
  output logic         txd
);
  localparam int FW  = W + 2;
  localparam int BIW = $clog2(FW);
  localparam int TW  = $clog2(TPB);

  ser_state_e     state;
  logic [W:0]     frame;
  logic [BIW-1:0] bit_idx;
  logic [TW-1:0]  tick_cnt;

  assign busy = (state == SER_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SER_IDLE;
      frame    <= '1;
      bit_idx  <= '0;
      tick_cnt <= '0;
      txd      <= 1'b1;
    end else if (load && state == SER_IDLE) begin
      state    <= SER_BUSY;
      frame    <= {1'b1, din};
      bit_idx  <= '0;
      tick_cnt <= '0;
      txd      <= 1'b0;
    end else if (state == SER_BUSY && baud_tick) begin
      if (tick_cnt == TW'(TPB - 1)) begin
        tick_cnt <= '0;
        if (bit_idx == BIW'(FW - 1)) begin
          state <= SER_IDLE;
          txd   <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          txd     <= frame[0];
          frame   <= {1'b1, frame[W:1]};
        end
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/thre_irq_ctrl.sv
module thre_irq_ctrl #(
  parameter int DLY = 144
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_empty,
  input  logic occ_ge2,
  input  logic wr_en,
  input  logic iid_rd,
  input  logic irq_en,
  input  logic baud_tick,
  output logic pend
);
  localparam int DW = $clog2(DLY);

  logic          prev_he;
  logic          armed;
  logic          waiting;
  logic [DW-1:0] dly_cnt;
  logic          ev, dly_done, set_now, rd_clr;

  always_comb begin
    ev       = hold_empty && !prev_he;
    dly_done = waiting && hold_empty && baud_tick && (dly_cnt == DW'(DLY - 1));
    set_now  = ev ? armed : dly_done;
    rd_clr   = iid_rd && irq_en && pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_he <= 1'b1;
      armed   <= 1'b0;
      waiting <= 1'b1;
      dly_cnt <= '0;
      pend    <= 1'b0;
    end else begin
      prev_he <= hold_empty;
      if (ev) begin
        armed   <= 1'b0;
        waiting <= !armed;
        dly_cnt <= '0;
      end else begin
        if (occ_ge2) armed <= 1'b1;
        if (waiting) begin
          if (!hold_empty) begin
            waiting <= 1'b0;
          end else if (baud_tick) begin
            if (dly_cnt == DW'(DLY - 1)) waiting <= 1'b0;
            else                         dly_cnt <= dly_cnt + 1'b1;
          end
        end
      end
      if (wr_en)        pend <= 1'b0;
      else if (set_now) pend <= 1'b1;
      else if (rd_clr)  pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_txempty_irq.sv
module uart_txempty_irq
  import uart_thre_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              iid_rd,
  input  logic              irq_en,
  input  logic              baud_tick,
  output logic              txd,
  output logic              hold_empty,
  output logic              xmit_empty,
  output logic              irq,
  output logic [3:0]        iid
);
  localparam int CW        = $clog2(FIFO_DEPTH + 1);
  localparam int DLY_TICKS = TICKS_PER_BIT * (DATA_W + 1);

  logic [CW-1:0]     count;
  logic [DATA_W-1:0] head;
  logic              busy, load, pend;

  assign load       = !busy && (count != '0);
  assign hold_empty = (count == '0);
  assign xmit_empty = hold_empty && !busy;
  assign irq        = pend && irq_en;
  assign iid        = irq ? IID_THRE : IID_NONE;

  txq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(wr_en), .din(wr_data),
    .pop(load), .head(head), .count(count)
  );

  tx_serializer #(.W(DATA_W), .TPB(TICKS_PER_BIT)) u_ser (
    .clk(clk), .rst(rst), .load(load), .din(head),
    .baud_tick(baud_tick), .busy(busy), .txd(txd)
  );

  thre_irq_ctrl #(.DLY(DLY_TICKS)) u_irq (
    .clk(clk), .rst(rst), .hold_empty(hold_empty),
    .occ_ge2(count >= CW'(2)), .wr_en(wr_en), .iid_rd(iid_rd),
    .irq_en(irq_en), .baud_tick(baud_tick), .pend(pend)
  );
endmodule

// File: rtl/uart_txempty_irq_chk.sv
module uart_txempty_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       iid_rd,
  input logic       txd,
  input logic       hold_empty,
  input logic       xmit_empty,
  input logic       irq,
  input logic [3:0] iid
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (txd && hold_empty && xmit_empty && !irq && iid == 4'b0001));

  assert_write_fills_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !hold_empty);

  assert_idle_line_high_R4: assert property (@(posedge clk) disable iff (rst)
    xmit_empty |-> txd);

  assert_path_empty_R5: assert property (@(posedge clk) disable iff (rst)
    xmit_empty |-> hold_empty);

  assert_irq_only_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> hold_empty);

  assert_write_clears_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !irq);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (iid_rd && irq) |=> !irq);

  assert_iid_form_R10: assert property (@(posedge clk) disable iff (rst)
    (iid[3:2] == 2'b00) && (iid[0] != iid[1]) && (iid[1] == irq));
endmodule

bind uart_txempty_irq uart_txempty_irq_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .iid_rd(iid_rd), .txd(txd),
  .hold_empty(hold_empty), .xmit_empty(xmit_empty), .irq(irq), .iid(iid)
);

// File: tb/uart_txempty_irq_test.sv
`timescale 1ns/1ps
module uart_txempty_irq_test;
  localparam int QDEPTH = 16;
  localparam int TPB    = 16;
  localparam int DLY    = 144;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, iid_rd = 1'b0, irq_en = 1'b0, baud_tick = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, hold_empty, xmit_empty, irq;
  logic [3:0] iid;

  int n_chk = 0, n_fail = 0, falls = 0;
  logic prev_txd = 1'b1;

  always #2.5 clk = ~clk;

  uart_txempty_irq uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .iid_rd(iid_rd),
    .irq_en(irq_en), .baud_tick(baud_tick), .txd(txd), .hold_empty(hold_empty),
    .xmit_empty(xmit_empty), .irq(irq), .iid(iid)
  );

  // reference model built from the requirements
  logic [7:0] mq[$];
  logic       mbusy, mtxd, mpend, marm, mwait, mprev;
  logic [8:0] mframe;
  int         mbit, mtick, mdly;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      mbusy = 0; mtxd = 1; mpend = 0; marm = 0; mwait = 1; mprev = 1;
      mframe = '1; mbit = 0; mtick = 0; mdly = 0;
    end else begin
      logic he, do_push, ev, set_it;
      he      = (mq.size() == 0);
      do_push = wr_en && (mq.size() < QDEPTH);
      ev      = he && !mprev;
      set_it  = 0;
      if (ev) begin
        set_it = marm; mwait = !marm; mdly = 0; marm = 0;
      end else begin
        if (mq.size() >= 2) marm = 1;
        if (mwait) begin
          if (!he) mwait = 0;
          else if (baud_tick) begin
            if (mdly == DLY - 1) begin set_it = 1; mwait = 0; end
            else mdly++;
          end
        end
      end
      if (wr_en) mpend = 0;
      else if (set_it) mpend = 1;
      else if (iid_rd && irq_en && mpend) mpend = 0;
      mprev = he;
      if (!mbusy && mq.size() > 0) begin
        mframe = {1'b1, mq.pop_front()};
        mbusy = 1; mbit = 0; mtick = 0; mtxd = 0;
      end else if (mbusy && baud_tick) begin
        if (mtick == TPB - 1) begin
          mtick = 0;
          if (mbit == 9) begin mbusy = 0; mtxd = 1; end
          else begin mbit++; mtxd = mframe[0]; mframe = {1'b1, mframe[8:1]}; end
        end else mtick++;
      end
      if (do_push) mq.push_back(wr_data);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_model();
    logic mhe, mirq;
    mhe  = (mq.size() == 0);
    mirq = mpend && irq_en;
    check("R4 txd vs model", txd, mtxd);
    check("R3 hold_empty vs model", hold_empty, mhe);
    check("R5 xmit_empty vs model", xmit_empty, mhe && !mbusy);
    check("R10 irq vs model", irq, mirq);
    check("R10 iid vs model", iid, mirq ? 2 : 1);
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic rd, input logic tk);
    wr_en = w; wr_data = d; iid_rd = rd; baud_tick = tk;
    @(negedge clk);
    wr_en = 0; iid_rd = 0; baud_tick = 0;
    compare_model();
    if (prev_txd && !txd) falls++;
    prev_txd = txd;
  endtask

  task automatic drain_hold(input logic tk);
    for (int g = 0; g < 4000 && !hold_empty; g++) step(0, 8'h00, 0, tk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): got hung run expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    @(negedge clk);
    repeat (3) step(0, 8'h00, 0, 0);
    check("R1 reset txd", txd, 1);
    check("R1 reset hold_empty", hold_empty, 1);
    check("R1 reset xmit_empty", xmit_empty, 1);
    check("R1 reset irq", irq, 0);
    check("R1 reset iid", iid, 1);
    rst = 1'b0;
    irq_en = 1'b1;

    repeat (DLY - 1) step(0, 8'h00, 0, 1);
    check("R7 no irq one tick before start-up delay", irq, 0);
    step(0, 8'h00, 0, 1);
    check("R7 irq at 144th tick after reset", irq, 1);
    check("R10 iid while pending", iid, 2);

    irq_en = 1'b0;
    step(0, 8'h00, 1, 0);
    check("R10 irq masked by enable", irq, 0);
    check("R10 iid with irq masked", iid, 1);
    irq_en = 1'b1;
    step(0, 8'h00, 0, 0);
    check("R9 masked read leaves interrupt pending", irq, 1);
    step(0, 8'h00, 1, 0);
    check("R9 read clears pending interrupt", irq, 0);
    repeat (5) step(0, 8'h00, 0, 1);
    check("R9 interrupt stays clear after read", irq, 0);

    step(1, 8'hA5, 0, 0);
    check("R3 write clears hold_empty", hold_empty, 0);
    step(1, 8'h3C, 0, 0);
    check("R4 start bit at load edge", txd, 0);
    check("R5 xmit_empty low while sending", xmit_empty, 0);
    step(1, 8'hC3, 0, 0);
    drain_hold(1);
    check("R6 irq not yet at hold_empty rise", irq, 0);
    step(0, 8'h00, 0, 0);
    check("R6 immediate irq after two queued", irq, 1);
    step(1, 8'h11, 0, 0);
    check("R8 write clears pending interrupt", irq, 0);

    drain_hold(1);
    step(0, 8'h00, 0, 0);
    repeat (10) step(0, 8'h00, 0, 0);
    check("R7 single character waits without ticks", irq, 0);
    repeat (DLY - 1) step(0, 8'h00, 0, 1);
    check("R7 no irq before delay after single character", irq, 0);
    step(0, 8'h00, 0, 1);
    check("R7 irq after delay following single character", irq, 1);

    rst = 1'b1; step(0, 8'h00, 0, 0); step(0, 8'h00, 0, 0); rst = 1'b0;
    irq_en = 1'b0;
    falls = 0;
    for (int i = 0; i < 20; i++) step(1, 8'hFF, 0, 0);
    check("R3 hold_empty low with full queue", hold_empty, 0);
    for (int g = 0; g < 6000 && !xmit_empty; g++) step(0, 8'h00, 0, 1);
    check("R2 frames sent after 20 writes into depth 16", falls, 17);
    check("R5 xmit_empty after all frames", xmit_empty, 1);

    irq_en = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      logic w, rd, tk;
      w  = ($urandom % 50) == 0;
      if (($urandom % 400) == 0) begin
        for (int b = 0; b < 2 + int'($urandom % 18); b++) step(1, 8'($urandom), 0, 1);
      end
      rd = ($urandom % 12) == 0;
      tk = ($urandom % 3) != 0;
      if (($urandom % 300) == 0) irq_en = ~irq_en;
      step(w, 8'($urandom), rd, tk);
    end

    finish_run();
  end
endmodule